// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog

This block is an operating-system tick source. A 32-bit up-counter advances by one on each cycle where `tick_i` is high; `tick_i` carries the enable from a fixed-rate timer clock. Four 32-bit compare registers sit beside the counter. When the counter steps onto a compare value, that channel can latch a status bit and drive its own interrupt line. Software acknowledges an interrupt by writing a one to its status bit.

Channel 3 also works as a one-shot watchdog. Software arms it through a one-bit enable register. The next channel-3 match then raises a single-cycle system reset request and clears the enable. Software reaches every register through a word-addressed write strobe and a combinational read port.

Top module: `os_match_timer`

## Requirements
- R1: After reset every register reads zero, `irq_o` and `reset_req_o` are low, and the counter stays at zero while `tick_i` is low.
- R2: A write to the count register loads the written value. Each later cycle with `tick_i` high adds one. When a count write and a tick fall in the same cycle, the written value is loaded and the tick is lost.
- R3: Byte offsets: compare register n (n = 0..3) at 4*n, count at 0x10, status at 0x14, watchdog enable at 0x18, interrupt enable at 0x1C. Writes and reads use these addresses.
- R4: When channel n matches and interrupt-enable bit n is 1, status bit n (read at 0x14, bit n) and `irq_o[n]` become 1 in the cycle after the matching tick edge, and they stay set. When the enable bit is 0, the match leaves status and `irq_o` unchanged.
- R5: A status write clears each bit whose written value is 1, and `irq_o` for that channel drops with it. Bits written as 0 keep their value. When a match and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: The interrupt-enable register stores only the low 12 bits of a write. The upper bits read as zero.
- R7: The watchdog register keeps only bit 0. While that bit is 1, a channel-3 match pulses `reset_req_o` high for exactly one cycle and clears the bit, whatever interrupt-enable bit 3 holds. A later channel-3 match gives no new request until the bit is written to 1 again.
- R8: Matching follows the counter across its wrap from 0xFFFFFFFF to 0.
- R9: A match is detected only on a tick that moves the counter onto the compare value. A load that lands on the compare value detects nothing, and so does holding the counter on it.
- R10: Reads of any other address, unaligned ones included, return zero. Writes to such an address change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable from the timer clock |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address, used for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 4 | Interrupt line for each channel |
| reset_req_o | output | 1 | Single-cycle system reset request |

## Verification
The bench aims at the counter wrap. A comparator that does not wrap would never fire on 1 once the count passes 0xFFFFFFFF. It also loads the count directly onto a compare value: a level comparator would fire there, and would fire again on every idle cycle. Count writes and status clears are issued in the same cycle as a tick. This catches a design that lets the tick override the load, or lets the clear swallow a new event. Finally, the watchdog is fired with interrupt-enable bit 3 off, then matched a second time. A design that gated the request on that enable bit stays silent, and one that never self-clears issues a second reset.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
  localparam int NCH     = 4;
  localparam int DW      = 32;
  localparam int AW      = 8;
  localparam int IEN_W   = 12;
  localparam int WDOG_CH = NCH - 1;
  localparam logic [AW-1:0] OFS_CNT  = 8'h10;
  localparam logic [AW-1:0] OFS_STAT = 8'h14;
  localparam logic [AW-1:0] OFS_WDOG = 8'h18;
  localparam logic [AW-1:0] OFS_IEN  = 8'h1C;
endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] nxt_o,
  output logic          step_o
);
  logic [DW-1:0] cnt_q;

  assign step_o = tick_i && !ld_i;
  assign nxt_o  = cnt_q + DW'(1);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_val_i;  // load beats tick
    else if (tick_i) cnt_q <= nxt_o;
  end

  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ld_i) |=> (cnt_q == $past(cnt_q) + DW'(1)));
  p_cnt_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_q == $past(ld_val_i)));
  p_cnt_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ostmr_match_chan.sv
module ostmr_match_chan #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          step_i,
  input  logic [DW-1:0] nxt_i,
  output logic [DW-1:0] match_o,
  output logic          hit_o
);
  logic [DW-1:0] match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   match_q <= '0;
    else if (wr_i) match_q <= wdata_i;
  end

  // edge-type compare: fires only when a tick moves the count onto the value
  assign hit_o   = step_i && (nxt_i == match_q);
  assign match_o = match_q;

  p_hit_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !wr_i) |=> !hit_o);
endmodule

// File: rtl/ostmr_wdog.sv
module ostmr_wdog (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic hit_i,
  output logic en_o,
  output logic req_o
);
  logic en_q, req_q;
  logic fire;

  assign fire = en_q && hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      req_q <= fire;
      if (fire)      en_q <= 1'b0;  // one-shot: firing wins over a write
      else if (wr_i) en_q <= wbit_i;
    end
  end

  assign en_o  = en_q;
  assign req_o = req_q;

  p_wdog_fire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && hit_i) |=> (req_q && !en_q));
  p_wdog_oneshot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> !en_q);
  p_wdog_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !req_q);
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
  import ostmr_pkg::*;
#(
  parameter int DW_P    = DW,
  parameter int AW_P    = AW,
  parameter int IEN_W_P = IEN_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            wr_i,
  input  logic [AW_P-1:0] addr_i,
  input  logic [DW_P-1:0] wdata_i,
  output logic [DW_P-1:0] rdata_o,
  output logic [NCH-1:0]  irq_o,
  output logic            reset_req_o
);
  logic [DW_P-1:0]    cnt, nxt;
  logic               step;
  logic [NCH-1:0]     hit, match_wr;
  logic [DW_P-1:0]    match_val [NCH];
  logic [NCH-1:0]     stat_q, stat_d;
  logic [IEN_W_P-1:0] ien_q;
  logic               wdog_en;
  logic               cnt_wr, stat_wr, wdog_wr, ien_wr;

  assign cnt_wr  = wr_i && (addr_i == AW_P'(OFS_CNT));
  assign stat_wr = wr_i && (addr_i == AW_P'(OFS_STAT));
  assign wdog_wr = wr_i && (addr_i == AW_P'(OFS_WDOG));
  assign ien_wr  = wr_i && (addr_i == AW_P'(OFS_IEN));

  ostmr_counter #(.DW(DW_P)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .ld_i(cnt_wr), .ld_val_i(wdata_i),
    .cnt_o(cnt), .nxt_o(nxt), .step_o(step)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    assign match_wr[n] = wr_i && (addr_i == AW_P'(4 * n));
    ostmr_match_chan #(.DW(DW_P)) u_chan (
      .clk_i, .rst_ni,
      .wr_i(match_wr[n]), .wdata_i(wdata_i),
      .step_i(step), .nxt_i(nxt),
      .match_o(match_val[n]), .hit_o(hit[n])
    );

    p_stat_needs_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stat_q[n] && !ien_q[n]) |=> !stat_q[n]);
    p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_wr && wdata_i[n] && !hit[n]) |=> !irq_o[n]);
    p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit[n] && ien_q[n]) |=> irq_o[n]);
  end

  ostmr_wdog u_wdog (
    .clk_i, .rst_ni,
    .wr_i(wdog_wr), .wbit_i(wdata_i[0]),
    .hit_i(hit[WDOG_CH]),
    .en_o(wdog_en), .req_o(reset_req_o)
  );

  // new events take priority over a same-cycle clear
  always_comb begin
    stat_d = stat_q;
    if (stat_wr) stat_d = stat_d & ~wdata_i[NCH-1:0];
    stat_d = stat_d | (hit & ien_q[NCH-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (ien_wr) ien_q <= wdata_i[IEN_W_P-1:0];
    end
  end

  assign irq_o = stat_q;

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < NCH; n++)
      if (addr_i == AW_P'(4 * n)) rdata_o = match_val[n];
    unique case (addr_i)
      AW_P'(OFS_CNT):  rdata_o = cnt;
      AW_P'(OFS_STAT): rdata_o = DW_P'(stat_q);
      AW_P'(OFS_WDOG): rdata_o = DW_P'(wdog_en);
      AW_P'(OFS_IEN):  rdata_o = DW_P'(ien_q);
      default: ;
    endcase
  end

  p_ien_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW_P'(OFS_IEN)) |-> (rdata_o[DW_P-1:IEN_W_P] == '0));
endmodule

// File: tb/os_match_timer_test.sv
module os_match_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  irq_o;
  logic        reset_req_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  os_match_timer uut (
    .clk_i, .rst_ni, .tick_i, .wr_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o, .reset_req_o
  );

  // {is_write, addr, data-or-expected}
  localparam int NV = 15;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'h1111_1111},
    {1'b1, 8'h04, 32'h2222_2222},
    {1'b1, 8'h08, 32'h3333_3333},
    {1'b1, 8'h0C, 32'h4444_4444},
    {1'b1, 8'h1C, 32'hFFFF_FFFF},
    {1'b1, 8'h10, 32'h0000_0ABC},
    {1'b1, 8'h24, 32'hDEAD_BEEF},
    {1'b0, 8'h00, 32'h1111_1111},
    {1'b0, 8'h04, 32'h2222_2222},
    {1'b0, 8'h08, 32'h3333_3333},
    {1'b0, 8'h0C, 32'h4444_4444},
    {1'b0, 8'h1C, 32'h0000_0FFF},
    {1'b0, 8'h10, 32'h0000_0ABC},
    {1'b0, 8'h24, 32'h0000_0000},
    {1'b0, 8'h14, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_i = 1'b0; tick_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    addr_i = a;
    #1 chk(tag, rdata_o, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      tick_i = 1'b1;
    end
    @(negedge clk_i);
    tick_i = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    #1;
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 reset_req", 32'(reset_req_o), 0);
    for (int a = 0; a < 32; a += 4) rd(8'(a), 0, "R1 reg zero");
    repeat (5) @(negedge clk_i);
    rd(8'h10, 0, "R1 counter held");

    // R3/R6/R10 vector table
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][40]) wr(VEC[v][39:32], VEC[v][31:0]);
      else rd(VEC[v][39:32], VEC[v][31:0], "R3 vector");
    end

    // R4 match with enable
    do_reset();
    wr(8'h1C, 32'h1);
    wr(8'h00, 32'd5);
    wr(8'h10, 32'd1);
    ticks(3);
    chk("R4 before match", 32'(irq_o), 0);
    ticks(1);
    chk("R4 irq set", 32'(irq_o), 32'h1);
    rd(8'h14, 32'h1, "R4 status set");
    ticks(2);
    chk("R4 sticky", 32'(irq_o), 32'h1);

    // R5 write-one-to-clear
    wr(8'h14, 32'h0);
    chk("R5 zero write keeps", 32'(irq_o), 32'h1);
    wr(8'h14, 32'h1);
    #1 chk("R5 cleared", 32'(irq_o), 0);
    ticks(3);
    rd(8'h14, 0, "R9 no refire");

    // R4 enable clear records nothing (count now 10)
    wr(8'h04, 32'd12);
    ticks(2);
    rd(8'h10, 32'd12, "R4 count at match");
    rd(8'h14, 0, "R4 disabled match");
    chk("R4 disabled irq", 32'(irq_o), 0);

    // R9 load onto compare value does not match
    wr(8'h1C, 32'h2);
    wr(8'h04, 32'h40);
    wr(8'h10, 32'h40);
    repeat (3) @(negedge clk_i);
    rd(8'h14, 0, "R9 load no match");
    ticks(1);
    rd(8'h14, 0, "R9 step off");

    // R8 wrap
    wr(8'h1C, 32'h4);
    wr(8'h08, 32'h1);
    wr(8'h10, 32'hFFFF_FFFE);
    ticks(2);
    rd(8'h10, 0, "R8 wrapped");
    rd(8'h14, 0, "R8 not yet");
    ticks(1);
    chk("R8 irq after wrap", 32'(irq_o), 32'h4);
    rd(8'h10, 32'h1, "R8 count");

    // R5 set beats same-cycle clear
    wr(8'h14, 32'h4);
    rd(8'h14, 0, "R5 cleared bit2");
    wr(8'h08, 32'h10);
    wr(8'h10, 32'h0F);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = 8'h14; wdata_i = 32'h4; tick_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; tick_i = 1'b0;
    rd(8'h14, 32'h4, "R5 set wins");

    // R2 load beats tick
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = 8'h10; wdata_i = 32'h100; tick_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; tick_i = 1'b0;
    rd(8'h10, 32'h100, "R2 load wins");
    ticks(1);
    rd(8'h10, 32'h101, "R2 continues");

    // R7 watchdog, ien bit3 off
    do_reset();
    wr(8'h18, 32'h1);
    rd(8'h18, 32'h1, "R7 armed");
    wr(8'h0C, 32'd3);
    ticks(2);
    chk("R7 no early req", 32'(reset_req_o), 0);
    ticks(1);
    chk("R7 req pulse", 32'(reset_req_o), 1);
    @(negedge clk_i);
    #1 chk("R7 pulse one cycle", 32'(reset_req_o), 0);
    rd(8'h18, 0, "R7 self cleared");
    rd(8'h14, 0, "R7 no status w/o enable");
    wr(8'h0C, 32'd4);
    ticks(1);
    chk("R7 one-shot", 32'(reset_req_o), 0);
    wr(8'h18, 32'h2);
    rd(8'h18, 0, "R7 bit0 only");

    // R10 unmapped
    wr(8'h00, 32'h55);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h20, 0, "R10 read 0x20");
    rd(8'h02, 0, "R10 unaligned");
    rd(8'h00, 32'h55, "R10 match0 kept");
    rd(8'h1C, 0, "R10 ien kept");
    rd(8'h18, 0, "R10 wdog kept");

    summary();
    $finish;
  end
endmodule